// File: doc/BRIEF.md
# Interrupt Line Combiner with Autovector Acknowledge

This block gathers four interrupt sources into the three active-low priority lines of a processor and answers the processor's interrupt acknowledge cycles. Each source owns one line bit. No priority encoder sits between the sources and the lines. The lowest line is shared by a timer/IO controller and a disk controller. A write strobe loads a mask bit that can block the disk controller's request. A serial controller owns the middle line. A debug push-button owns the top line, and it reaches that line only after a debounce filter sees a steady level.

Two rules keep the level the processor sees well defined. First, the lowest line is withdrawn whenever the middle line is active. Second, an active top line forces both lower lines inactive, so the only levels that can appear are 0, 1, 2 and 4. The all-active pattern, the non-maskable level 7, can never be produced.

The processor signals an interrupt acknowledge by driving an address in the top sixteen bytes of its address space while the address strobe is low. The block recognises this and pulls the active-low peripheral-valid response down, so that the processor autovectors. It releases the response one clock after the strobe goes high.

Top module: `irq_glue`

## Requirements
- R1: After reset, `ipl_n` is 3'b111, `vpa_n` is 1 and the disk mask bit is 0 (disk unmasked).
- R2: With the switch filter inactive, `ser_irq` low and either `tmr_irq` high or (`dsk_irq` high with mask 0), `ipl_n` reads 3'b110 one clock later. Bit 0 of `ipl_n` is the lowest line, bit 2 the top line.
- R3: A clock edge with `mask_we` high loads `mask_wdata` into the mask bit. The new value governs `ipl_n` from the following edge onward. With mask 1, `dsk_irq` alone leaves `ipl_n` at 3'b111.
- R4: With the switch filter inactive and `ser_irq` high, `ipl_n` reads 3'b101 one clock later, whatever the lowest-priority sources request.
- R5: Once the debounced switch is pressed, `ipl_n` reads 3'b011 (level 4), with both lower lines forced inactive.
- R6: The switch (`dbg_sw_n` low = pressed) changes its filtered state only after the raw level has differed from the filtered state for DEB_CYCLES consecutive clock edges. The top line follows one edge after that. A shorter glitch has no effect on `ipl_n`.
- R7: `ipl_n` is never 3'b000.
- R8: `vpa_n` is low one clock after an edge at which `as_n` is low and `addr` is in 0xFFFFF0..0xFFFFFF. At any other address, or with `as_n` high, it is high.
- R9: `vpa_n` returns high at the first clock edge after `as_n` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_irq | input | 1 | Timer/IO controller request, active high |
| dsk_irq | input | 1 | Disk controller request, active high |
| ser_irq | input | 1 | Serial controller request, active high |
| dbg_sw_n | input | 1 | Raw debug push-button, low when pressed |
| mask_we | input | 1 | Write strobe for the disk mask bit |
| mask_wdata | input | 1 | Value written to the disk mask bit (1 blocks the disk) |
| as_n | input | 1 | Processor address strobe, active low |
| addr | input | ADDR_W | Processor address bus |
| ipl_n | output | 3 | Active-low priority lines, bit 0 lowest |
| vpa_n | output | 1 | Active-low peripheral-valid response for autovectoring |

## Verification
A stale disk mask bit shows up at `ipl_n[0]` on the first cycle in which the disk requests alone after the write. The bench therefore writes the mask under changing disk activity and compares every cycle. A debounce counter that does not clear, or that fires early, moves the top line's transition by one or more cycles, or lets a short glitch through. Every cycle is checked against a reference model, so the very cycle where the behaviour diverges is reported. A sticky acknowledge state shows as `vpa_n` still low one cycle after the strobe rises, which the same per-cycle comparison catches at once.

// File: rtl/irq_glue_pkg.sv
package irq_glue_pkg;

    // Priority level presented to the processor, as a plain number
    typedef enum logic [2:0] {
        LVL_NONE = 3'd0,
        LVL_LOW  = 3'd1,
        LVL_MID  = 3'd2,
        LVL_TOP  = 3'd4
    } irq_level_e;

    // Registered state of the level combiner
    typedef struct packed {
        logic       mask;
        logic [2:0] ipl_n;
    } comb_state_t;

    // Registered state of the acknowledge decoder
    typedef struct packed {
        logic vpa_n;
    } ack_state_t;

    function automatic logic [2:0] level_to_lines(irq_level_e lvl);
        return ~lvl;
    endfunction

endpackage

// File: rtl/irq_debounce.sv
module irq_debounce #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_on,
    output logic stable_on
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    typedef struct packed {
        logic             stable;
        logic [CNT_W-1:0] cnt;
    } deb_state_t;

    deb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_on == st_q.stable) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.stable = raw_on;
            st_d.cnt    = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stable_on = st_q.stable;

endmodule

// File: rtl/irq_level_comb.sv
module irq_level_comb
    import irq_glue_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tmr_req,
    input  logic       dsk_req,
    input  logic       ser_req,
    input  logic       top_req,
    input  logic       mask_we,
    input  logic       mask_wdata,
    output logic       mask_o,
    output logic [2:0] ipl_n
);
    comb_state_t st_d, st_q;
    irq_level_e  lvl;
    logic        low_any;

    always_comb begin
        st_d    = st_q;
        low_any = tmr_req | (dsk_req & ~st_q.mask);
        if (top_req)      lvl = LVL_TOP;
        else if (ser_req) lvl = LVL_MID;
        else if (low_any) lvl = LVL_LOW;
        else              lvl = LVL_NONE;
        st_d.ipl_n = level_to_lines(lvl);
        if (mask_we) st_d.mask = mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask  <= 1'b0;
            st_q.ipl_n <= 3'b111;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign ipl_n  = st_q.ipl_n;

endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode
    import irq_glue_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LOW_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              vpa_n
);
    localparam int HI_W = ADDR_W - LOW_BITS;

    ack_state_t st_d, st_q;
    logic       in_window;

    always_comb begin
        st_d      = st_q;
        in_window = (addr[ADDR_W-1:LOW_BITS] == {HI_W{1'b1}});
        st_d.vpa_n = ~(~as_n & in_window);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.vpa_n <= 1'b1;
        else        st_q <= st_d;
    end

    assign vpa_n = st_q.vpa_n;

endmodule

// File: rtl/irq_glue.sv
module irq_glue #(
    parameter int ADDR_W     = 24,
    parameter int ACK_LOW    = 4,
    parameter int DEB_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_irq,
    input  logic              dsk_irq,
    input  logic              ser_irq,
    input  logic              dbg_sw_n,
    input  logic              mask_we,
    input  logic              mask_wdata,
    input  logic              as_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        ipl_n,
    output logic              vpa_n
);
    logic sw_on;
    logic mask_q;

    irq_debounce #(.CYCLES(DEB_CYCLES)) u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_on    (~dbg_sw_n),
        .stable_on (sw_on)
    );

    irq_level_comb u_comb (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_req    (tmr_irq),
        .dsk_req    (dsk_irq),
        .ser_req    (ser_irq),
        .top_req    (sw_on),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .mask_o     (mask_q),
        .ipl_n      (ipl_n)
    );

    irq_ack_decode #(.ADDR_W(ADDR_W), .LOW_BITS(ACK_LOW)) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .as_n  (as_n),
        .addr  (addr),
        .vpa_n (vpa_n)
    );

endmodule

// File: rtl/irq_glue_chk.sv
module irq_glue_chk #(
    parameter int ADDR_W  = 24,
    parameter int ACK_LOW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tmr_irq,
    input logic              ser_irq,
    input logic              mask_we,
    input logic              mask_wdata,
    input logic              as_n,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        ipl_n,
    input logic              vpa_n,
    input logic              sw_on,
    input logic              mask_q
);
    // R7
    no_level7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_n != 3'b000);

    // R4
    low_withdrawn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ipl_n[1] |-> ipl_n[0]);

    // R5
    top_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ipl_n[2] |-> (ipl_n[1:0] == 2'b11));

    // R2
    low_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_on && !ser_irq && tmr_irq) |=> (ipl_n == 3'b110));

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_wdata)));

    // R8
    vpa_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && (addr[ADDR_W-1:ACK_LOW] == {(ADDR_W-ACK_LOW){1'b1}})) |=> !vpa_n);

    // R9
    vpa_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> vpa_n);

endmodule

bind irq_glue irq_glue_chk #(.ADDR_W(ADDR_W), .ACK_LOW(ACK_LOW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_irq    (tmr_irq),
    .ser_irq    (ser_irq),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .as_n       (as_n),
    .addr       (addr),
    .ipl_n      (ipl_n),
    .vpa_n      (vpa_n),
    .sw_on      (sw_on),
    .mask_q     (mask_q)
);

// File: tb/irq_glue_tb_top.sv
module irq_glue_tb_top;
    localparam int AW  = 24;
    localparam int DEB = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tmr_irq = 0, dsk_irq = 0, ser_irq = 0, dbg_sw_n = 1;
    logic          mask_we = 0, mask_wdata = 0, as_n = 1;
    logic [AW-1:0] addr = '0;
    logic [2:0]    ipl_n;
    logic          vpa_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_mask = 0;
    bit m_sw = 0;
    int m_cnt = 0;
    logic [2:0] exp_ipl = 3'b111;
    logic       exp_vpa = 1'b1;
    logic       prev_as_n = 1'b1;

    always #10 clk = ~clk;

    irq_glue #(.ADDR_W(AW), .ACK_LOW(4), .DEB_CYCLES(DEB)) dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_irq(tmr_irq), .dsk_irq(dsk_irq),
        .ser_irq(ser_irq), .dbg_sw_n(dbg_sw_n), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .as_n(as_n), .addr(addr),
        .ipl_n(ipl_n), .vpa_n(vpa_n)
    );

    function automatic logic [2:0] lines_fn(bit sw, bit ser, bit tmr, bit dsk, bit msk);
        if (sw)                 return 3'b011;
        if (ser)                return 3'b101;
        if (tmr || (dsk && !msk)) return 3'b110;
        return 3'b111;
    endfunction

    function automatic logic vpa_fn(logic a_n, logic [AW-1:0] a);
        return !(!a_n && (a >= 24'hFFFFF0));
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    // inputs are already applied (just after a negedge); predict the next edge
    task automatic step();
        exp_ipl = lines_fn(m_sw, ser_irq, tmr_irq, dsk_irq, m_mask);
        exp_vpa = vpa_fn(as_n, addr);
        prev_as_n = as_n;
        if (mask_we) m_mask = mask_wdata;
        if (!dbg_sw_n == m_sw) m_cnt = 0;
        else if (m_cnt == DEB - 1) begin m_sw = !dbg_sw_n; m_cnt = 0; end
        else m_cnt++;
        @(negedge clk);
        begin
            string t;
            if (exp_ipl == 3'b011)      t = "R5";
            else if (exp_ipl == 3'b101) t = "R4";
            else if (mask_we || (m_mask && exp_ipl == 3'b111)) t = "R3";
            else                        t = "R2";
            chk(t, {1'b0, ipl_n}, {1'b0, exp_ipl});
        end
        chk(prev_as_n ? "R9" : "R8", {3'b0, vpa_n}, {3'b0, exp_vpa});
        checks++;
        if (ipl_n === 3'b000) begin
            errors++;
            $display("FAIL R7 actual=%b expected=not 000", ipl_n);
        end
    endtask

    task automatic rand_inputs(bit sw_hold);
        tmr_irq    = ($urandom % 10) < 3;
        dsk_irq    = ($urandom % 10) < 4;
        ser_irq    = ($urandom % 4) == 0;
        mask_we    = ($urandom % 10) == 0;
        mask_wdata = $urandom % 2;
        as_n       = ($urandom % 10) >= 4;
        if ($urandom % 2) addr = {20'hFFFFF, 4'($urandom)};
        else              addr = AW'($urandom);
        if (!sw_hold && ($urandom % 40) == 0) dbg_sw_n = ~dbg_sw_n;
    endtask

    task automatic quiet();
        tmr_irq = 0; dsk_irq = 0; ser_irq = 0; mask_we = 0; as_n = 1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {1'b0, ipl_n}, 4'b0111);
        chk("R1", {3'b0, vpa_n}, 4'b0001);
        rst_n = 1'b1;

        // R1 mask is 0 after reset: disk alone raises the low line
        quiet(); dsk_irq = 1; step();
        chk("R1", {1'b0, ipl_n}, 4'b0110);

        // R3 mask blocks disk; R2 timer still passes
        mask_we = 1; mask_wdata = 1; step();
        mask_we = 0; step();
        chk("R3", {1'b0, ipl_n}, 4'b0111);
        tmr_irq = 1; step();
        chk("R2", {1'b0, ipl_n}, 4'b0110);

        // R4 serial withdraws the low line
        ser_irq = 1; step();
        chk("R4", {1'b0, ipl_n}, 4'b0101);

        // R8 window boundaries
        quiet(); as_n = 0; addr = 24'hFFFFEF; step();
        chk("R8", {3'b0, vpa_n}, 4'b0001);
        addr = 24'hFFFFF0; step();
        chk("R8", {3'b0, vpa_n}, 4'b0000);
        addr = 24'hFFFFFF; step();
        chk("R8", {3'b0, vpa_n}, 4'b0000);
        // R9 release one clock after strobe rises
        as_n = 1; step();
        chk("R9", {3'b0, vpa_n}, 4'b0001);

        // R6 glitch shorter than the filter
        quiet(); dbg_sw_n = 0;
        for (int i = 0; i < DEB - 2; i++) step();
        dbg_sw_n = 1; step(); step();
        chk("R6", {1'b0, ipl_n}, 4'b0111);

        // R6 / R5 press held: top line appears exactly after DEB+1 edges
        dbg_sw_n = 0; ser_irq = 1; tmr_irq = 1;
        for (int i = 0; i < DEB; i++) step();
        chk("R6", {1'b0, ipl_n}, 4'b0101);
        step();
        chk("R5", {1'b0, ipl_n}, 4'b0011);
        dbg_sw_n = 1;
        for (int i = 0; i < DEB + 2; i++) step();
        chk("R6", {1'b0, ipl_n}, 4'b0101);

        // random mix with the switch mostly held
        for (int i = 0; i < 4000; i++) begin
            rand_inputs(1'b0);
            step();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule